// File: doc/BRIEF.md
# Interrupt Arbitration and Entry Sequencer

This block sits beside a small 16-bit processor core. It decides which pending interrupt request is serviced and walks the core through entry into the service routine. It watches a reset request, three non-maskable sources and a parameterised set of maskable peripheral request lines. At an instruction boundary it saves the return context on the stack and then fetches the handler address.

Only two words are saved by hardware: the return program counter, then the status word. Each stack write goes through a valid/ready push port. The push address is the stack pointer minus 2, then minus 4. The handler address is read through a second valid/ready port. After both are done, the core gets a one-cycle strobe that loads the new program counter and stack pointer.

Back-pressure rules: a port that raises valid keeps it high, with a constant address and data, until it sees ready high at a clock edge. The entry sequence waits in that step for as long as ready stays low. With both ready inputs held high, entry takes a fixed six cycles.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, push_valid, vec_valid, pc_load, sr_clr, flag_clr and nmi_en are all zero.
- R2: Source priority, highest first, is: reset request, NMI pin, oscillator fault, flash violation, maskable line 0, then each following maskable line in index order. The vectors are 16'hFFFE for reset, 16'hFFFC for all three non-maskable sources, and 16'hFFFA - 2*i for maskable line i.
- R3: A non-maskable request is taken regardless of gie. It is gated only by its own nmi_en bit: bit 0 is the pin, bit 1 the oscillator, bit 2 the flash. Its flag is latched by a rising nmi_pin edge while nmi_mode=1, or by a one-cycle pulse on osc_fault or flash_viol. A latched flag stays pending while its enable is 0.
- R4: Accepting a non-maskable or reset request clears all three nmi_en bits. They stay zero until nmi_en_wr writes them.
- R5: Maskable line i is pending only when mask_req[i], mask_en[i] and gie are all 1.
- R6: Entry timing, counting the clock edge that samples insn_done=1 with a request pending as the accepting edge:
  - In the cycle after the accepting edge, the push port carries the PC at sp_in-2.
  - In the next cycle, it carries the status word at sp_in-4. The PC, status word and sp_in used are the values sampled at the accepting edge.
  - In the next cycle, sr_clr is high.
  - In the next cycle, vec_valid is high with the vector.
  - In the next cycle, pc_load is high with pc_load_val equal to the fetched word and sp_new equal to sp_in-4.
- R7: In the sr_clr cycle, flag_clr[i] pulses for the winning maskable line only if bit i of SINGLE_MASK is 1. Non-maskable and reset flags are cleared inside the block.
- R8: While push_valid or vec_valid is high and its ready is low, the valid, address and data stay unchanged and the sequence waits.
- R9: The winner is chosen in the sr_clr cycle, from the requests pending at that moment. A request that arrives during entry is therefore not lost. A request that does not win stays pending for a later entry.
- R10: A reset request is accepted in the idle state without insn_done, and nothing is pushed. Its vector is 16'hFFFE, and sp_new equals the sp_in sampled at acceptance.
- R11: Exactly two push handshakes occur per interrupt entry, and none occur in the sr_clr, vector or load cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Reset request pulse |
| nmi_pin | input | 1 | Reset/NMI pin level |
| nmi_mode | input | 1 | Pin acts as NMI source when 1 |
| osc_fault | input | 1 | Oscillator fault pulse |
| flash_viol | input | 1 | Flash access violation pulse |
| nmi_en_wr | input | 1 | Write strobe for the non-maskable enables |
| nmi_en_wdata | input | 3 | Enable values written by nmi_en_wr |
| nmi_en | output | 3 | Current non-maskable enables |
| mask_req | input | NUM_MASK | Maskable request flags |
| mask_en | input | NUM_MASK | Per-line maskable enables |
| gie | input | 1 | Global enable bit of the status word |
| insn_done | input | 1 | Instruction boundary strobe |
| pc_next | input | DW | Address of the next instruction |
| sr_in | input | DW | Current status word |
| sp_in | input | AW | Current stack pointer |
| push_valid | output | 1 | Stack write request |
| push_ready | input | 1 | Stack write accepted |
| push_addr | output | AW | Stack write address |
| push_data | output | DW | Stack write data |
| sr_clr | output | 1 | Clear-status-word strobe |
| flag_clr | output | NUM_MASK | Auto-clear strobes for single-source flags |
| vec_valid | output | 1 | Vector read request |
| vec_ready | input | 1 | Vector read completed |
| vec_addr | output | AW | Vector address |
| vec_data | input | DW | Vector word, sampled on the handshake |
| pc_load | output | 1 | Load PC and SP strobe |
| pc_load_val | output | DW | New program counter |
| sp_new | output | AW | New stack pointer |

## Verification
The bench uses the defaults NUM_MASK=4 and SINGLE_MASK=4'b0101. With these, every maskable line can win, including the lowest vector at 16'hFFF4. Both single-source lines (flag_clr pulses) and multi-source lines (no pulse) are covered. Stall lengths of two cycles on both ports show the sequence stretching without losing its saved context.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NMI_N   = 3;
  localparam int FIXED_N = NMI_N + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PC,
    ST_SR,
    ST_SEL,
    ST_VEC,
    ST_LOAD
  } seq_st_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             nmi_pin,
  input  logic             nmi_mode,
  input  logic             osc_fault,
  input  logic             flash_viol,
  input  logic             en_wr,
  input  logic [NMI_N-1:0] en_wdata,
  input  logic             clr_rst,
  input  logic [NMI_N-1:0] clr_nmi,
  input  logic             clr_en_all,
  output logic             rst_flag,
  output logic [NMI_N-1:0] nmi_flag,
  output logic [NMI_N-1:0] nmi_en
);
  logic             pin_q;
  logic [NMI_N-1:0] set_v;

  assign set_v = {flash_viol, osc_fault, nmi_mode & nmi_pin & ~pin_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 1'b0;
      rst_flag <= 1'b0;
      nmi_flag <= '0;
      nmi_en   <= '0;
    end else begin
      pin_q    <= nmi_pin;
      rst_flag <= (rst_flag & ~clr_rst) | rst_req;
      nmi_flag <= (nmi_flag & ~clr_nmi) | set_v;
      if (clr_en_all)  nmi_en <= '0;
      else if (en_wr)  nmi_en <= en_wdata;
    end
  end

  // R4
  nmi_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_all |=> nmi_en == '0);

  // R3
  nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_fault && !clr_nmi[1]) |=> nmi_flag[1]);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int              NSRC    = 8,
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   VEC_TOP = 16'hFFFE
) (
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] sel,
  output logic [AW-1:0]   vaddr
);
  logic [NSRC-1:0] higher;

  assign higher[0] = 1'b0;
  for (genvar k = 1; k < NSRC; k++) begin : g_chain
    assign higher[k] = higher[k-1] | pend[k-1];
  end
  assign sel = pend & ~higher;

  always_comb begin
    vaddr = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel[k]) begin
        if (k == 0)      vaddr = VEC_TOP;
        else if (k < 4)  vaddr = VEC_TOP - AW'(2);
        else             vaddr = VEC_TOP - AW'(2 * (k - 2));
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int                  NUM_MASK    = 4,
  parameter int                  AW          = 16,
  parameter int                  DW          = 16,
  parameter logic [NUM_MASK-1:0] SINGLE_MASK = 4'b0101,
  localparam int                 NSRC        = FIXED_N + NUM_MASK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_req,
  input  logic                nmi_pin,
  input  logic                nmi_mode,
  input  logic                osc_fault,
  input  logic                flash_viol,
  input  logic                nmi_en_wr,
  input  logic [NMI_N-1:0]    nmi_en_wdata,
  output logic [NMI_N-1:0]    nmi_en,
  input  logic [NUM_MASK-1:0] mask_req,
  input  logic [NUM_MASK-1:0] mask_en,
  input  logic                gie,
  input  logic                insn_done,
  input  logic [DW-1:0]       pc_next,
  input  logic [DW-1:0]       sr_in,
  input  logic [AW-1:0]       sp_in,
  output logic                push_valid,
  input  logic                push_ready,
  output logic [AW-1:0]       push_addr,
  output logic [DW-1:0]       push_data,
  output logic                sr_clr,
  output logic [NUM_MASK-1:0] flag_clr,
  output logic                vec_valid,
  input  logic                vec_ready,
  output logic [AW-1:0]       vec_addr,
  input  logic [DW-1:0]       vec_data,
  output logic                pc_load,
  output logic [DW-1:0]       pc_load_val,
  output logic [AW-1:0]       sp_new
);
  seq_st_e         st_q;
  logic [DW-1:0]   pc_q, sr_q, load_q;
  logic [AW-1:0]   sp_q, vec_q;
  logic [NSRC-1:0] snap_q, win_q, pend, pick_in, sel;
  logic [AW-1:0]   vaddr;
  logic            rst_flag, clr_rst, clr_en_all;
  logic [NMI_N-1:0] nmi_flag, clr_nmi;
  logic            in_sel;

  irq_src_bank u_src (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_pin(nmi_pin),
    .nmi_mode(nmi_mode), .osc_fault(osc_fault), .flash_viol(flash_viol),
    .en_wr(nmi_en_wr), .en_wdata(nmi_en_wdata), .clr_rst(clr_rst),
    .clr_nmi(clr_nmi), .clr_en_all(clr_en_all), .rst_flag(rst_flag),
    .nmi_flag(nmi_flag), .nmi_en(nmi_en)
  );

  assign pend    = {mask_req & mask_en & {NUM_MASK{gie}}, nmi_flag & nmi_en, rst_flag};
  assign in_sel  = (st_q == ST_SEL);
  assign pick_in = (in_sel && pend == '0) ? snap_q : pend;

  irq_prio_pick #(.NSRC(NSRC), .AW(AW), .VEC_TOP(AW'(16'hFFFE))) u_pick (
    .pend(pick_in), .sel(sel), .vaddr(vaddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      sr_q   <= '0;
      sp_q   <= '0;
      snap_q <= '0;
      win_q  <= '0;
      vec_q  <= '0;
      load_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (rst_flag) begin
            sp_q   <= sp_in;
            snap_q <= pend;
            st_q   <= ST_SEL;
          end else if (insn_done && |pend[NSRC-1:1]) begin
            pc_q   <= pc_next;
            sr_q   <= sr_in;
            sp_q   <= sp_in;
            snap_q <= pend;
            st_q   <= ST_PC;
          end
        end
        ST_PC:  if (push_ready) st_q <= ST_SR;
        ST_SR:  if (push_ready) st_q <= ST_SEL;
        ST_SEL: begin
          win_q <= sel;
          vec_q <= vaddr;
          st_q  <= ST_VEC;
        end
        ST_VEC: if (vec_ready) begin
          load_q <= vec_data;
          st_q   <= ST_LOAD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign push_valid  = (st_q == ST_PC) || (st_q == ST_SR);
  assign push_addr   = (st_q == ST_PC) ? sp_q - AW'(2) : sp_q - AW'(4);
  assign push_data   = (st_q == ST_PC) ? pc_q : sr_q;
  assign sr_clr      = in_sel;
  assign flag_clr    = in_sel ? (sel[NSRC-1:FIXED_N] & SINGLE_MASK) : '0;
  assign clr_rst     = in_sel & sel[0];
  assign clr_nmi     = in_sel ? sel[NMI_N:1] : '0;
  assign clr_en_all  = in_sel & (|sel[NMI_N:0]);
  assign vec_valid   = (st_q == ST_VEC);
  assign vec_addr    = vec_q;
  assign pc_load     = (st_q == ST_LOAD);
  assign pc_load_val = load_q;
  assign sp_new      = win_q[0] ? sp_q : sp_q - AW'(4);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R8
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> push_valid && $stable(push_addr) && $stable(push_data));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> vec_valid && $stable(vec_addr));

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr) && ((flag_clr & ~SINGLE_MASK) == '0));

  // R6
  load_after_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> pc_load && (pc_load_val == $past(vec_data)));
endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic rst_req = 0, nmi_pin = 0, nmi_mode = 1, osc_fault = 0, flash_viol = 0;
  logic nmi_en_wr = 0;
  logic [2:0] nmi_en_wdata = 0, nmi_en;
  logic [N-1:0] mask_req = 0, mask_en = 0, flag_clr;
  logic gie = 0, insn_done = 0;
  logic [15:0] pc_next = 0, sr_in = 0, sp_in = 16'h0400;
  logic push_valid, push_ready = 1, sr_clr, vec_valid, vec_ready = 1, pc_load;
  logic [15:0] push_addr, push_data, vec_addr, vec_data, pc_load_val, sp_new;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign vec_data = vec_addr ^ 16'h5A5A;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_pin(nmi_pin),
    .nmi_mode(nmi_mode), .osc_fault(osc_fault), .flash_viol(flash_viol),
    .nmi_en_wr(nmi_en_wr), .nmi_en_wdata(nmi_en_wdata), .nmi_en(nmi_en),
    .mask_req(mask_req), .mask_en(mask_en), .gie(gie), .insn_done(insn_done),
    .pc_next(pc_next), .sr_in(sr_in), .sp_in(sp_in), .push_valid(push_valid),
    .push_ready(push_ready), .push_addr(push_addr), .push_data(push_data),
    .sr_clr(sr_clr), .flag_clr(flag_clr), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_data(vec_data),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .sp_new(sp_new)
  );

  // row: nmi_en(3) pulse{flash,osc,pin}(3) req(4) men(4) gie(1) vec(16) clr(4) nmi_cleared(1)
  localparam logic [35:0] TBL [8] = '{
    {3'b000, 3'b000, 4'b0001, 4'b1111, 1'b1, 16'hFFFA, 4'b0001, 1'b0},
    {3'b000, 3'b000, 4'b1010, 4'b1111, 1'b1, 16'hFFF8, 4'b0000, 1'b0},
    {3'b000, 3'b000, 4'b1100, 4'b0111, 1'b1, 16'hFFF6, 4'b0100, 1'b0},
    {3'b000, 3'b000, 4'b1000, 4'b1000, 1'b1, 16'hFFF4, 4'b0000, 1'b0},
    {3'b111, 3'b010, 4'b0001, 4'b1111, 1'b1, 16'hFFFC, 4'b0000, 1'b1},
    {3'b100, 3'b100, 4'b0010, 4'b1111, 1'b0, 16'hFFFC, 4'b0000, 1'b1},
    {3'b001, 3'b001, 4'b1111, 4'b1111, 1'b1, 16'hFFFC, 4'b0000, 1'b1},
    {3'b000, 3'b010, 4'b0001, 4'b0001, 1'b1, 16'hFFFA, 4'b0001, 1'b0}
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic write_en(input logic [2:0] v);
    @(negedge clk); nmi_en_wr = 1; nmi_en_wdata = v;
    @(posedge clk); @(negedge clk); nmi_en_wr = 0;
  endtask

  task automatic do_entry(input logic [15:0] exp_vec, input logic [3:0] exp_clr,
                          input int stall, input bit mid_flash, input logic [15:0] pcv);
    logic [15:0] srv, spv;
    srv = pcv ^ 16'h00F8; spv = 16'h0400 + {pcv[3:0], 1'b0};
    @(negedge clk); pc_next = pcv; sr_in = srv; sp_in = spv; insn_done = 1;
    @(posedge clk); @(negedge clk); insn_done = 0;
    if (mid_flash) flash_viol = 1;
    check(push_valid && push_addr == spv - 2 && push_data == pcv, "R6 pc push", {push_addr, push_data}, {spv - 16'd2, pcv});
    if (stall > 0) begin
      push_ready = 0;
      for (int s = 0; s < stall; s++) begin
        @(posedge clk); @(negedge clk); flash_viol = 0;
        check(push_valid && push_data == pcv && push_addr == spv - 2, "R8 push stall", {push_addr, push_data}, {spv - 16'd2, pcv});
      end
      push_ready = 1;
    end
    @(posedge clk); @(negedge clk); flash_viol = 0;
    check(push_valid && push_addr == spv - 4 && push_data == srv, "R6 sr push", {push_addr, push_data}, {spv - 16'd4, srv});
    @(posedge clk); @(negedge clk);
    check(sr_clr && !push_valid, "R11 sr_clr cycle no push", {sr_clr, push_valid}, 2'b10);
    check(flag_clr == exp_clr, "R7 flag_clr", flag_clr, exp_clr);
    @(posedge clk); @(negedge clk);
    check(vec_valid && vec_addr == exp_vec && !push_valid, "R2 vector", vec_addr, exp_vec);
    if (stall > 0) begin
      vec_ready = 0;
      for (int s = 0; s < stall; s++) begin
        @(posedge clk); @(negedge clk);
        check(vec_valid && vec_addr == exp_vec && !pc_load, "R8 vec stall", vec_addr, exp_vec);
      end
      vec_ready = 1;
    end
    @(posedge clk); @(negedge clk);
    check(pc_load && pc_load_val == (exp_vec ^ 16'h5A5A) && !push_valid, "R6 pc_load", pc_load_val, exp_vec ^ 16'h5A5A);
    check(sp_new == spv - 4, "R6 sp_new", sp_new, spv - 16'd4);
    @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); @(negedge clk);
    // R1
    check(!push_valid && !vec_valid && !pc_load && !sr_clr && flag_clr == 0 && nmi_en == 0,
          "R1 reset state", {push_valid, vec_valid, pc_load, sr_clr, flag_clr, nmi_en}, 0);

    for (int r = 0; r < 8; r++) begin
      logic [35:0] row;
      row = TBL[r];
      write_en(row[35:33]);
      mask_req = row[29:26]; mask_en = row[25:22]; gie = row[21];
      nmi_pin = row[30]; osc_fault = row[31]; flash_viol = row[32];
      @(posedge clk); @(negedge clk); osc_fault = 0; flash_viol = 0;
      do_entry(row[20:5], row[4:1], 0, 0, 16'h1230 + 16'(r));
      if (row[0]) check(nmi_en == 0, "R4 nmi_en cleared", nmi_en, 0);
      else        check(nmi_en == row[35:33], "R3 nmi_en kept", nmi_en, row[35:33]);
      @(negedge clk); mask_req = 0; nmi_pin = 0;
    end

    // R5: gie low blocks maskable requests
    @(negedge clk); mask_req = 4'b0001; mask_en = 4'b1111; gie = 0; insn_done = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(!push_valid && !vec_valid, "R5 gie=0 blocks", push_valid, 0);
    // R5: per-line enable low blocks
    gie = 1; mask_en = 4'b1110;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(!push_valid && !vec_valid, "R5 mask_en=0 blocks", push_valid, 0);
    insn_done = 0; mask_req = 0; mask_en = 4'b1111;

    // R3: osc flag latched while disabled, taken once enabled
    write_en(3'b010);
    do_entry(16'hFFFC, 4'b0000, 0, 0, 16'h2000);
    check(nmi_en == 0, "R4 enables cleared after held osc", nmi_en, 0);

    // R9: flash arrives during a maskable entry and wins the late selection
    write_en(3'b100);
    @(negedge clk); mask_req = 4'b0001; mask_en = 4'b0001; gie = 1;
    do_entry(16'hFFFC, 4'b0000, 2, 1, 16'h3000);
    check(nmi_en == 0, "R9 nmi_en after late nmi", nmi_en, 0);
    do_entry(16'hFFFA, 4'b0001, 0, 0, 16'h3002);
    @(negedge clk); mask_req = 0;

    // R10: reset request, no pushes
    write_en(3'b111);
    @(negedge clk); sp_in = 16'h0444; rst_req = 1;
    @(posedge clk); @(negedge clk); rst_req = 0;
    @(posedge clk); @(negedge clk);
    check(sr_clr && !push_valid, "R10 reset direct to select", {sr_clr, push_valid}, 2'b10);
    @(posedge clk); @(negedge clk);
    check(vec_valid && vec_addr == 16'hFFFE, "R10 reset vector", vec_addr, 16'hFFFE);
    @(posedge clk); @(negedge clk);
    check(pc_load && sp_new == 16'h0444 && pc_load_val == (16'hFFFE ^ 16'h5A5A), "R10 reset load", sp_new, 16'h0444);
    check(nmi_en == 0, "R10 reset clears nmi_en", nmi_en, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule